// File: doc/BRIEF.md
# Transmit Auto-Retransmit Controller

This block sequences the transmitting side of a packet radio link. It moves between powered-down, two idle levels, transmit, acknowledgement-wait and retry-wait states. Its inputs are the power-up and chip-enable controls, a transmit-queue empty flag, the auto-acknowledge and per-packet no-acknowledge settings, and abstract strobes from the radio datapath: transmit finished, acknowledgement seen, acknowledgement window expired. A packet that is not acknowledged is sent again after a programmable delay, up to a programmable number of retries. When the retry budget runs out, a sticky failure flag is raised and the packet stays queued.

The block keeps two 4-bit counters. One counts the retries of the current packet. The other counts lost packets across transactions, saturates, and clears only when the channel is rewritten. Success pops the transmit queue with a one-cycle strobe and raises a sticky sent flag. Software clears each flag by a write-one pulse. The retry delay is timed in units of a microsecond tick input. No payload passes through this block, so it has no valid/ready interface. Every pin is a plain level or a single-cycle strobe, and the queue pop cannot be back-pressured: the queue must accept a pop in any cycle.

Mode codes: 0 power down, 1 standby-I, 2 standby-II, 3 transmit, 4 acknowledgement wait, 5 retry wait. All outputs are registered and change on the same clock edge as the mode.

Top module: `txlink_ctrl`

## Requirements
- R1: After reset, mode is 0 and fifo_pop, sent_flag, maxrt_flag, retry_cnt and lost_cnt are all 0.
- R2: With pwr_up low, mode is 0 after the next edge, from any state, and a running retry delay is abandoned. From mode 0 with pwr_up high, mode becomes 1 after one edge.
- R3: In mode 1 with ce high, the queue non-empty and maxrt_flag clear, the block enters mode 3 and clears retry_cnt to 0 (a new packet). In mode 1 with ce high and the queue empty, it enters mode 2.
- R4: In mode 2, a non-empty queue (with maxrt_flag clear) moves the block to mode 3 after one edge. Lowering ce moves it to mode 1.
- R5: In mode 3, tx_done with auto_ack low or no_ack high ends the packet. At that edge sent_flag becomes 1, fifo_pop is 1 for exactly one cycle, and mode becomes 1.
- R6: In mode 3, tx_done with auto_ack high and no_ack low moves the block to mode 4 without a pop. In mode 4, ack_rcvd ends the packet as in R5.
- R7: In mode 4, ack_tmo with retry_cnt below retry_max enters mode 5. After exactly (retry_delay+1)×STEP_US us_tick pulses, the block re-enters mode 3, and retry_cnt increments at that edge.
- R8: In mode 4, ack_tmo with retry_cnt equal to retry_max sets maxrt_flag, returns to mode 1 and does not pop. With retry_max 0, the first timeout fails.
- R9: Each ack_tmo increments lost_cnt, which holds at 15. A chan_wr pulse clears it to 0 at the next edge and takes priority over an increment.
- R10: While maxrt_flag is 1, mode 3 is never entered. Each of clr_maxrt and clr_sent clears its own flag at the next edge; a set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle microsecond tick for the retry delay |
| pwr_up | input | 1 | Power-up control |
| ce | input | 1 | Chip enable |
| auto_ack | input | 1 | Auto-acknowledge enabled |
| no_ack | input | 1 | Head packet requests no acknowledgement |
| fifo_empty | input | 1 | Transmit queue is empty |
| retry_delay | input | 4 | Delay code; wait is (code+1)×STEP_US ticks |
| retry_max | input | 4 | Maximum retransmissions; 0 disables retries |
| chan_wr | input | 1 | Channel register written (clears lost_cnt) |
| tx_done | input | 1 | Transmission finished strobe |
| ack_rcvd | input | 1 | Acknowledgement received strobe |
| ack_tmo | input | 1 | Acknowledgement window expired strobe |
| clr_sent | input | 1 | Write-one clear of sent_flag |
| clr_maxrt | input | 1 | Write-one clear of maxrt_flag |
| mode | output | 3 | Current mode code |
| fifo_pop | output | 1 | One-cycle pop of the transmitted packet |
| sent_flag | output | 1 | Sticky packet-sent flag |
| maxrt_flag | output | 1 | Sticky retry-exhausted flag |
| retry_cnt | output | 4 | Retransmissions of the current packet |
| lost_cnt | output | 4 | Saturating lost-packet count |

## Verification
The properties assume that tx_done arrives only in mode 3, and that ack_rcvd and ack_tmo arrive only in mode 4, never together. They also assume retry_max is held steady for the whole of a transaction. The stimulus meets these assumptions. Each strobe is raised only after the bench has observed the matching mode at a falling edge. Retry settings change only while the block is idle or blocked by the failure flag. The queue is modelled from the bench's own load and pop counts, so fifo_empty changes only in response to the block's own pops.

// File: rtl/txlink_pkg.sv
package txlink_pkg;
  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_IDLE1 = 3'd1,
    M_IDLE2 = 3'd2,
    M_SEND  = 3'd3,
    M_ACKW  = 3'd4,
    M_RWAIT = 3'd5
  } link_mode_t;
  localparam int CNT_W = 4;
endpackage

// File: rtl/txlink_delay.sv
module txlink_delay #(
  parameter int STEP_US = 250,
  parameter int CODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              expire
);
  localparam int MAX_WAIT = (1 << CODE_W) * STEP_US;
  localparam int TW       = $clog2(MAX_WAIT + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;

  always_comb begin
    lim    = TW'((32'(code) + 32'd1) * 32'(STEP_US));
    expire = run && tick && (cnt == lim - TW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/txlink_counters.sv
module txlink_counters #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          new_pkt,
  input  logic          retx,
  input  logic          lost,
  input  logic          chan_wr,
  output logic [CW-1:0] retry_cnt,
  output logic [CW-1:0] lost_cnt
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retry_cnt <= '0;
      lost_cnt  <= '0;
    end else begin
      if (new_pkt)   retry_cnt <= '0;
      else if (retx) retry_cnt <= retry_cnt + CW'(1);
      if (chan_wr)                   lost_cnt <= '0;
      else if (lost && lost_cnt != SAT) lost_cnt <= lost_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/txlink_flags.sv
module txlink_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_ok,
  input  logic done_fail,
  input  logic clr_sent,
  input  logic clr_maxrt,
  output logic sent_flag,
  output logic maxrt_flag,
  output logic fifo_pop
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_flag  <= 1'b0;
      maxrt_flag <= 1'b0;
      fifo_pop   <= 1'b0;
    end else begin
      fifo_pop <= done_ok;
      if (done_ok)        sent_flag <= 1'b1;
      else if (clr_sent)  sent_flag <= 1'b0;
      if (done_fail)      maxrt_flag <= 1'b1;
      else if (clr_maxrt) maxrt_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/txlink_ctrl.sv
module txlink_ctrl
  import txlink_pkg::*;
#(
  parameter int STEP_US = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             pwr_up,
  input  logic             ce,
  input  logic             auto_ack,
  input  logic             no_ack,
  input  logic             fifo_empty,
  input  logic [CNT_W-1:0] retry_delay,
  input  logic [CNT_W-1:0] retry_max,
  input  logic             chan_wr,
  input  logic             tx_done,
  input  logic             ack_rcvd,
  input  logic             ack_tmo,
  input  logic             clr_sent,
  input  logic             clr_maxrt,
  output logic [2:0]       mode,
  output logic             fifo_pop,
  output logic             sent_flag,
  output logic             maxrt_flag,
  output logic [CNT_W-1:0] retry_cnt,
  output logic [CNT_W-1:0] lost_cnt
);
  link_mode_t st, nx;
  logic ev_new, ev_retx, ev_lost, ev_ok, ev_fail, tmr_exp;

  always_comb begin
    nx = st; ev_new = 1'b0; ev_retx = 1'b0;
    ev_lost = 1'b0; ev_ok = 1'b0; ev_fail = 1'b0;
    unique case (st)
      M_OFF:   nx = M_IDLE1;
      M_IDLE1: begin
        if (ce && !fifo_empty && !maxrt_flag) begin
          nx = M_SEND; ev_new = 1'b1;
        end else if (ce && fifo_empty) nx = M_IDLE2;
      end
      M_IDLE2: begin
        if (!ce) nx = M_IDLE1;
        else if (!fifo_empty && !maxrt_flag) begin
          nx = M_SEND; ev_new = 1'b1;
        end
      end
      M_SEND: begin
        if (tx_done) begin
          if (auto_ack && !no_ack) nx = M_ACKW;
          else begin nx = M_IDLE1; ev_ok = 1'b1; end
        end
      end
      M_ACKW: begin
        if (ack_rcvd) begin
          nx = M_IDLE1; ev_ok = 1'b1;
        end else if (ack_tmo) begin
          ev_lost = 1'b1;
          if (retry_cnt == retry_max) begin
            nx = M_IDLE1; ev_fail = 1'b1;
          end else nx = M_RWAIT;
        end
      end
      M_RWAIT: begin
        if (tmr_exp) begin nx = M_SEND; ev_retx = 1'b1; end
      end
      default: nx = M_OFF;
    endcase
    if (!pwr_up) begin
      nx = M_OFF; ev_new = 1'b0; ev_retx = 1'b0;
      ev_lost = 1'b0; ev_ok = 1'b0; ev_fail = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= M_OFF;
    else        st <= nx;
  end

  assign mode = st;

  txlink_delay #(.STEP_US(STEP_US), .CODE_W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .run(st == M_RWAIT && pwr_up),
    .tick(us_tick), .code(retry_delay), .expire(tmr_exp)
  );

  txlink_counters #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .new_pkt(ev_new), .retx(ev_retx),
    .lost(ev_lost), .chan_wr(chan_wr),
    .retry_cnt(retry_cnt), .lost_cnt(lost_cnt)
  );

  txlink_flags u_flags (
    .clk(clk), .rst_n(rst_n), .done_ok(ev_ok), .done_fail(ev_fail),
    .clr_sent(clr_sent), .clr_maxrt(clr_maxrt),
    .sent_flag(sent_flag), .maxrt_flag(maxrt_flag), .fifo_pop(fifo_pop)
  );
endmodule

// File: rtl/txlink_ctrl_chk.sv
module txlink_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_up,
  input logic       chan_wr,
  input logic       clr_maxrt,
  input logic [2:0] mode,
  input logic       fifo_pop,
  input logic       sent_flag,
  input logic       maxrt_flag,
  input logic [3:0] retry_cnt,
  input logic [3:0] lost_cnt,
  input logic [3:0] retry_max
);
  AST_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> mode == 3'd0); // R2
  AST_POP_MEANS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> sent_flag); // R5
  AST_FAIL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(maxrt_flag) |-> !fifo_pop); // R8
  AST_BLOCKED_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (maxrt_flag && !clr_maxrt && mode != 3'd3) |=> mode != 3'd3); // R10
  AST_LOSS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_cnt == 4'hF && !chan_wr) |=> lost_cnt == 4'hF); // R9
  AST_CHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> lost_cnt == 4'h0); // R9
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5) |-> retry_cnt < retry_max); // R7
endmodule

bind txlink_ctrl txlink_ctrl_chk u_chk (.*);

// File: tb/txlink_ctrl_tb.sv
module txlink_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 250;

  logic clk = 0, rst_n = 0, us_tick = 1, pwr_up = 0, ce = 0;
  logic auto_ack = 0, no_ack = 0, chan_wr = 0, tx_done = 0;
  logic ack_rcvd = 0, ack_tmo = 0, clr_sent = 0, clr_maxrt = 0;
  logic [3:0] retry_delay = 0, retry_max = 0;
  logic fifo_empty;
  logic [2:0] mode;
  logic fifo_pop, sent_flag, maxrt_flag;
  logic [3:0] retry_cnt, lost_cnt;

  int errors = 0, checks = 0, loads = 0, pops = 0, tickcnt = 0;
  bit half = 0, done = 0;
  int m_st = 0, m_arc = 0, m_plos = 0, m_wait = 0;
  bit m_ds = 0, m_mr = 0, m_pop = 0;

  assign fifo_empty = (loads == pops);
  always #(CLK_PERIOD/2) clk = ~clk;

  txlink_ctrl #(.STEP_US(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pwr_up(pwr_up), .ce(ce),
    .auto_ack(auto_ack), .no_ack(no_ack), .fifo_empty(fifo_empty),
    .retry_delay(retry_delay), .retry_max(retry_max), .chan_wr(chan_wr),
    .tx_done(tx_done), .ack_rcvd(ack_rcvd), .ack_tmo(ack_tmo),
    .clr_sent(clr_sent), .clr_maxrt(clr_maxrt), .mode(mode),
    .fifo_pop(fifo_pop), .sent_flag(sent_flag), .maxrt_flag(maxrt_flag),
    .retry_cnt(retry_cnt), .lost_cnt(lost_cnt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    us_tick <= half ? ~us_tick : 1'b1;
    if (fifo_pop) pops++;
  end

  always @(posedge clk) if (mode == 3'd5 && us_tick) tickcnt++;

  // behavioural reference model
  always @(posedge clk) begin
    int nxt; bit ok, lost, fail, nw, rt;
    if (!rst_n) begin
      m_st = 0; m_arc = 0; m_plos = 0; m_ds = 0; m_mr = 0; m_pop = 0; m_wait = 0;
    end else begin
      ok = 0; lost = 0; fail = 0; nw = 0; rt = 0; nxt = m_st;
      if (!pwr_up) nxt = 0;
      else case (m_st)
        0: nxt = 1;
        1: if (ce && !fifo_empty && !m_mr) begin nxt = 3; nw = 1; end
           else if (ce && fifo_empty) nxt = 2;
        2: if (!ce) nxt = 1;
           else if (!fifo_empty && !m_mr) begin nxt = 3; nw = 1; end
        3: if (tx_done) begin
             if (auto_ack && !no_ack) nxt = 4; else begin ok = 1; nxt = 1; end
           end
        4: if (ack_rcvd) begin ok = 1; nxt = 1; end
           else if (ack_tmo) begin
             lost = 1;
             if (m_arc == int'(retry_max)) begin fail = 1; nxt = 1; end
             else begin nxt = 5; m_wait = 0; end
           end
        5: if (us_tick) begin
             m_wait++;
             if (m_wait == (int'(retry_delay) + 1) * STEP) begin nxt = 3; rt = 1; end
           end
        default: nxt = 0;
      endcase
      m_st = nxt;
      m_pop = ok;
      if (ok) m_ds = 1; else if (clr_sent) m_ds = 0;
      if (fail) m_mr = 1; else if (clr_maxrt) m_mr = 0;
      if (nw) m_arc = 0; else if (rt) m_arc++;
      if (chan_wr) m_plos = 0; else if (lost && m_plos < 15) m_plos++;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 mode vs model", int'(mode), m_st);
    chk("R5 pop vs model", int'(fifo_pop), int'(m_pop));
    chk("R6 sent vs model", int'(sent_flag), int'(m_ds));
    chk("R8 maxrt vs model", int'(maxrt_flag), int'(m_mr));
    chk("R7 retry_cnt vs model", int'(retry_cnt), m_arc);
    chk("R9 lost_cnt vs model", int'(lost_cnt), m_plos);
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  task automatic step(); @(negedge clk); endtask
  task automatic wait_mode(int m);
    for (int k = 0; k < 20000 && int'(mode) != m; k++) @(negedge clk);
  endtask
  task automatic p_txdone(); tx_done = 1; step(); tx_done = 0; endtask
  task automatic p_ack();    ack_rcvd = 1; step(); ack_rcvd = 0; endtask
  task automatic p_tmo();    ack_tmo = 1; step(); ack_tmo = 0; endtask

  initial begin
    retry_max = 4'd3;
    repeat (3) step();
    chk("R1 mode", int'(mode), 0); chk("R1 pop", int'(fifo_pop), 0);
    chk("R1 sent", int'(sent_flag), 0); chk("R1 maxrt", int'(maxrt_flag), 0);
    chk("R1 retry_cnt", int'(retry_cnt), 0); chk("R1 lost_cnt", int'(lost_cnt), 0);
    rst_n = 1; step();
    chk("R2 stays off", int'(mode), 0);
    pwr_up = 1; step(); chk("R2 up to idle1", int'(mode), 1);
    ce = 1; step(); chk("R3 empty to idle2", int'(mode), 2);
    loads++; step(); chk("R4 load starts send", int'(mode), 3);
    p_txdone();
    chk("R5 no-ack mode", int'(mode), 1); chk("R5 pop", int'(fifo_pop), 1);
    chk("R5 sent", int'(sent_flag), 1);
    step(); chk("R5 pop one cycle", int'(fifo_pop), 0); chk("R3 idle2", int'(mode), 2);
    clr_sent = 1; step(); clr_sent = 0; chk("R10 clear sent", int'(sent_flag), 0);

    auto_ack = 1; loads++; step(); chk("R4 send", int'(mode), 3);
    p_txdone(); chk("R6 ack wait", int'(mode), 4); chk("R6 no pop yet", int'(fifo_pop), 0);
    p_ack(); chk("R6 pop on ack", int'(fifo_pop), 1); chk("R6 sent", int'(sent_flag), 1);
    step();
    no_ack = 1; loads++; step(); p_txdone();
    chk("R5 no_ack skips wait", int'(mode), 1); chk("R5 pop", int'(fifo_pop), 1);
    no_ack = 0; step();

    clr_sent = 1; retry_max = 4'd2; retry_delay = 4'd0; loads++; step(); clr_sent = 0;
    for (int a = 0; a < 3; a++) begin
      wait_mode(3); p_txdone(); tickcnt = 0; p_tmo();
      if (a < 2) begin
        chk("R7 retry wait", int'(mode), 5);
        wait_mode(3);
        chk("R7 delay ticks", tickcnt, STEP); chk("R7 retry count", int'(retry_cnt), a + 1);
      end
    end
    chk("R8 fail to idle1", int'(mode), 1); chk("R8 maxrt", int'(maxrt_flag), 1);
    chk("R8 no pop", int'(fifo_pop), 0); chk("R9 lost 3", int'(lost_cnt), 3);
    repeat (5) step(); chk("R10 blocked", int'(mode), 1);
    clr_maxrt = 1; step(); clr_maxrt = 0; chk("R10 cleared", int'(maxrt_flag), 0);
    step(); chk("R3 new send", int'(mode), 3); chk("R3 retry cleared", int'(retry_cnt), 0);
    p_txdone(); p_ack(); step();

    retry_max = 4'd15; loads++; step();
    for (int a = 0; a < 16; a++) begin wait_mode(3); p_txdone(); p_tmo(); end
    chk("R8 fail at 15", int'(maxrt_flag), 1); chk("R9 saturate", int'(lost_cnt), 15);
    chan_wr = 1; step(); chan_wr = 0; chk("R9 channel clear", int'(lost_cnt), 0);

    half = 1; retry_max = 4'd1; retry_delay = 4'd1;
    clr_maxrt = 1; step(); clr_maxrt = 0;
    wait_mode(3); p_txdone(); tickcnt = 0; p_tmo(); wait_mode(3);
    chk("R7 delay code 1", tickcnt, 2 * STEP); chk("R7 retry 1", int'(retry_cnt), 1);
    p_txdone(); p_ack(); step();
    half = 0; retry_max = 4'd3; retry_delay = 4'd3; loads++;
    wait_mode(3); p_txdone(); p_tmo(); repeat (100) step();
    chk("R7 still waiting", int'(mode), 5);
    pwr_up = 0; step(); chk("R2 abort wait", int'(mode), 0);
    pwr_up = 1; step(); chk("R2 up again", int'(mode), 1);
    step(); chk("R3 resend", int'(mode), 3); chk("R3 fresh count", int'(retry_cnt), 0);
    p_txdone(); p_ack(); chk("R6 final pop", int'(fifo_pop), 1);
    repeat (3) step();
    finish_run();
  end
endmodule